// File: doc/BRIEF.md
# Word-Streamed Receive Frame Buffer

This block holds received frames in a circular memory and hands them to a host as a stream of 32-bit words. A frame writer pushes one word per cycle. The first word of each frame is marked with a strobe. It is a header whose word-count field gives the frame's length. The host pulls one word from `out_word` each time it asserts `pop`. The block finds frame boundaries on its own by loading a remaining-bytes counter from each header as that header is read.

A whole frame is either accepted or refused, and the decision is made when its header arrives. A frame that would not fit into the free space is dropped entirely and raises an overrun flag. A frame is counted only after its last word has been stored, and the stored-frame counter drives the not-empty and empty indications. The host also sees the read and write byte pointers, the free space, the total size in words, a running count of accepted frames, a flush command and a command that clears the overrun flag.

Top module: `rx_word_stream_buf`

## Requirements
- R1: The header word-count field sits in bits [15:11] of a frame's first word. A frame with count N occupies (N+1)*4 bytes. The words of an accepted frame are read back on `out_word` in the order they were written, header first.
- R2: In the cycle after the last word of an accepted frame is sampled, `frames_stored` and `frames_total` each rise by one, `stat_not_empty` and `stat_busy` are 1, `stat_idle` is 0, and `ev_rx` is high for exactly that one cycle.
- R3: If the stored bytes plus the new frame's length would exceed the buffer size when its header arrives, no word of that frame is stored. Stored bytes and frame count are unchanged, `stat_overrun` is set, and `ev_overrun` pulses for one cycle.
- R4: A `pop` while no bytes are stored returns 0 on `out_word` and leaves the pointers and free space unchanged.
- R5: On the pop of a frame's header, a remaining-bytes counter is loaded with N*4+4, and each pop removes 4 bytes. `frames_stored` falls by one only when the frame's last word is popped. When it reaches 0, `stat_not_empty` and `stat_busy` clear and `stat_idle` sets.
- R6: `rd_ptr` is a byte address that advances by 4 on each pop, modulo the buffer size. `wr_ptr` equals (`rd_ptr` + stored bytes) modulo the buffer size.
- R7: `free_words` is (buffer size − stored bytes)/4. `size_words` is the buffer size divided by 4.
- R8: `stat_empty` is 1 exactly when `frames_stored` is 0. `stat_full` is 1 exactly when the stored bytes equal the buffer size.
- R9: `flush` zeroes the read pointer, the stored bytes, the remaining-bytes counter and the frame count. It abandons a frame that is partly written, clears `stat_busy`, and leaves `frames_total` unchanged.
- R10: `clr_overrun` clears `stat_overrun`. If an overrun occurs in the same cycle, the flag stays set.
- R11: Words without the first-word strobe are ignored unless a frame is being accepted. A new first-word strobe in the middle of a frame abandons the partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Writer word valid |
| in_first | input | 1 | Marks the header word of a frame |
| in_word | input | 32 | Writer word |
| pop | input | 1 | Host consumes the word on out_word |
| out_word | output | 32 | Word at the read pointer, 0 when nothing is stored |
| flush | input | 1 | Discard all stored content |
| clr_overrun | input | 1 | Clear the overrun flag |
| stat_not_empty | output | 1 | At least one complete frame is stored |
| stat_empty | output | 1 | No complete frame is stored |
| stat_full | output | 1 | Stored bytes equal the buffer size |
| stat_overrun | output | 1 | A frame was dropped for lack of space |
| stat_busy | output | 1 | Receiving: set on accept, cleared when the buffer drains |
| stat_idle | output | 1 | Inverse of stat_busy |
| ev_rx | output | 1 | One-cycle pulse per accepted frame |
| ev_overrun | output | 1 | One-cycle pulse per dropped frame |
| rd_ptr | output | log2(BUF_BYTES) | Read byte pointer |
| wr_ptr | output | log2(BUF_BYTES) | Write byte pointer |
| free_words | output | log2(BUF_BYTES/4)+1 | Free space in words |
| size_words | output | log2(BUF_BYTES/4)+1 | Buffer size in words |
| frames_stored | output | log2(BUF_BYTES/4)+1 | Complete frames held |
| frames_total | output | TOTAL_W | Accepted frames since reset, wrapping |

## Verification
Frames of 1, 3, 4, 8, 28 and 32 words are pushed in a sequence that fills the buffer exactly, and then overflows it both by a whole large frame and by a single word. This separates an off-by-one in the fit test from a correct one. Reads interleaved with writes carry the read pointer past the end of the memory, which exposes pointer-wrap errors and write pointers computed from the wrong base. Partial reads followed by a flush, stray words without a header, and a header that restarts a frame part-way through separate a correctly reset remaining-bytes counter from a stale one. An overrun that coincides with a clear command shows which of the two takes priority.

// File: rtl/rxfb_pkg.sv
`timescale 1ns/1ps
package rxfb_pkg;

  // Header word-count field position: the frame writer and the reader both decode it.
  localparam int unsigned HDR_WCNT_LSB = 11;
  localparam int unsigned HDR_WCNT_W   = 5;

  function automatic logic [HDR_WCNT_W-1:0] hdr_wcnt(input logic [31:0] word);
    return word[HDR_WCNT_LSB +: HDR_WCNT_W];
  endfunction

  // Stored length of a frame in bytes, from its header word count.
  function automatic int unsigned frame_bytes(input logic [HDR_WCNT_W-1:0] wcnt);
    return (32'(wcnt) + 32'd1) * 32'd4;
  endfunction

  function automatic logic frame_fits(input int unsigned used, input int unsigned len,
                                      input int unsigned cap);
    return (used + len) <= cap;
  endfunction

  function automatic int unsigned occ_next(input int unsigned used, input logic add,
                                           input int unsigned add_bytes, input logic sub);
    return used + (add ? add_bytes : 32'd0) - (sub ? 32'd4 : 32'd0);
  endfunction

endpackage

// File: rtl/rxfb_mem.sv
`timescale 1ns/1ps
module rxfb_mem #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rxfb_ingest.sv
`timescale 1ns/1ps
module rxfb_ingest
  import rxfb_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned AW        = 9,
  parameter int unsigned BW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [31:0]   in_word,
  input  logic          flush,
  input  logic [BW:0]   used_bytes,
  input  logic [AW-1:0] base_waddr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [31:0]   wdata,
  output logic          commit,
  output logic [BW:0]   commit_bytes,
  output logic          drop
);
  logic                  active_q;
  logic [HDR_WCNT_W-1:0] left_q;
  logic [HDR_WCNT_W-1:0] off_q;
  logic [BW:0]           len_q;
  logic [HDR_WCNT_W-1:0] hw;
  int unsigned           hlen;
  logic                  hdr_ok, start, cont;

  always_comb begin
    hw     = hdr_wcnt(in_word);
    hlen   = frame_bytes(hw);
    hdr_ok = frame_fits(32'(used_bytes), hlen, BUF_BYTES);
    start  = in_valid && in_first && !flush;
    cont   = in_valid && !in_first && active_q && !flush;
    drop   = start && !hdr_ok;
    we     = (start && hdr_ok) || cont;
    waddr  = base_waddr + (start ? '0 : AW'(off_q));
    wdata  = in_word;
    commit = (start && hdr_ok && hw == '0) || (cont && left_q == HDR_WCNT_W'(1));
    commit_bytes = start ? (BW+1)'(hlen) : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
      off_q    <= '0;
      len_q    <= '0;
    end else if (flush) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= hdr_ok && (hw != '0);
      left_q   <= hw;
      off_q    <= HDR_WCNT_W'(1);
      len_q    <= (BW+1)'(hlen);
    end else if (cont) begin
      left_q <= left_q - HDR_WCNT_W'(1);
      off_q  <= off_q + HDR_WCNT_W'(1);
      if (left_q == HDR_WCNT_W'(1)) active_q <= 1'b0;
    end
  end

  // R3: a committed frame never takes the occupancy past the buffer size
  assert_commit_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (32'(used_bytes) + 32'(commit_bytes)) <= BUF_BYTES);
endmodule

// File: rtl/rxfb_drain.sv
`timescale 1ns/1ps
module rxfb_drain
  import rxfb_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          flush,
  input  logic          have_data,
  input  logic [31:0]   head_word,
  output logic [AW-1:0] rd_word,
  output logic          do_pop,
  output logic          frame_done
);
  localparam int unsigned REM_W = HDR_WCNT_W + 3;

  logic [REM_W-1:0] rem_q, rem_cur, rem_nx;

  always_comb begin
    do_pop     = pop && have_data && !flush;
    rem_cur    = (rem_q == '0) ? REM_W'(frame_bytes(hdr_wcnt(head_word))) : rem_q;
    rem_nx     = rem_cur - REM_W'(4);
    frame_done = do_pop && (rem_nx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
      rem_q   <= '0;
    end else if (flush) begin
      rd_word <= '0;
      rem_q   <= '0;
    end else if (do_pop) begin
      rd_word <= rd_word + AW'(1);
      rem_q   <= rem_nx;
    end
  end

  // R4: popping an empty buffer leaves the read position alone
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !have_data && !flush) |=> $stable(rd_word));
  // R5: a frame that is part-way read still has bytes stored behind it
  assert_mid_frame_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0) |-> have_data);
endmodule

// File: rtl/rx_word_stream_buf.sv
`timescale 1ns/1ps
module rx_word_stream_buf
  import rxfb_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned TOTAL_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic                           in_first,
  input  logic [31:0]                    in_word,
  input  logic                           pop,
  output logic [31:0]                    out_word,
  input  logic                           flush,
  input  logic                           clr_overrun,
  output logic                           stat_not_empty,
  output logic                           stat_empty,
  output logic                           stat_full,
  output logic                           stat_overrun,
  output logic                           stat_busy,
  output logic                           stat_idle,
  output logic                           ev_rx,
  output logic                           ev_overrun,
  output logic [$clog2(BUF_BYTES)-1:0]   rd_ptr,
  output logic [$clog2(BUF_BYTES)-1:0]   wr_ptr,
  output logic [$clog2(BUF_BYTES/4):0]   free_words,
  output logic [$clog2(BUF_BYTES/4):0]   size_words,
  output logic [$clog2(BUF_BYTES/4):0]   frames_stored,
  output logic [TOTAL_W-1:0]             frames_total
);
  localparam int unsigned DEPTH = BUF_BYTES / 4;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned BW    = $clog2(BUF_BYTES);

  logic [BW:0]          used_q;
  logic [AW:0]          frames_q;
  logic                 busy_q, ovr_q, ev_rx_q, ev_ovr_q;
  logic [TOTAL_W-1:0]   total_q;

  logic                 mem_we, commit, drop, do_pop, frame_done, have_data;
  logic [AW-1:0]        mem_waddr, rd_word, base_waddr;
  logic [31:0]          mem_wdata, head_word;
  logic [BW:0]          commit_bytes;

  assign have_data  = (used_q != '0);
  assign base_waddr = rd_word + AW'(used_q >> 2);

  rxfb_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_word), .rdata(head_word)
  );

  rxfb_ingest #(.BUF_BYTES(BUF_BYTES), .AW(AW), .BW(BW)) u_ingest (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .in_word(in_word),
    .flush(flush), .used_bytes(used_q), .base_waddr(base_waddr),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .commit(commit), .commit_bytes(commit_bytes), .drop(drop)
  );

  rxfb_drain #(.AW(AW)) u_drain (
    .clk(clk), .rst_n(rst_n), .pop(pop), .flush(flush), .have_data(have_data),
    .head_word(head_word), .rd_word(rd_word), .do_pop(do_pop), .frame_done(frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q   <= '0;
      frames_q <= '0;
      busy_q   <= 1'b0;
      ovr_q    <= 1'b0;
      ev_rx_q  <= 1'b0;
      ev_ovr_q <= 1'b0;
      total_q  <= '0;
    end else begin
      ev_rx_q  <= commit;
      ev_ovr_q <= drop;
      if (drop)             ovr_q <= 1'b1;
      else if (clr_overrun) ovr_q <= 1'b0;
      if (commit) total_q <= total_q + TOTAL_W'(1);
      if (flush) begin
        used_q   <= '0;
        frames_q <= '0;
        busy_q   <= 1'b0;
      end else begin
        used_q <= (BW+1)'(occ_next(32'(used_q), commit, 32'(commit_bytes), do_pop));
        case ({commit, frame_done})
          2'b10:   frames_q <= frames_q + (AW+1)'(1);
          2'b01:   frames_q <= frames_q - (AW+1)'(1);
          default: frames_q <= frames_q;
        endcase
        if (commit)                                      busy_q <= 1'b1;
        else if (frame_done && frames_q == (AW+1)'(1))   busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    out_word       = have_data ? head_word : '0;
    stat_not_empty = (frames_q != '0);
    stat_empty     = (frames_q == '0);
    stat_full      = (used_q == (BW+1)'(BUF_BYTES));
    stat_overrun   = ovr_q;
    stat_busy      = busy_q;
    stat_idle      = !busy_q;
    ev_rx          = ev_rx_q;
    ev_overrun     = ev_ovr_q;
    rd_ptr         = {rd_word, 2'b00};
    wr_ptr         = rd_ptr + BW'(used_q);
    free_words     = (AW+1)'((BUF_BYTES - 32'(used_q)) >> 2);
    size_words     = (AW+1)'(DEPTH);
    frames_stored  = frames_q;
    frames_total   = total_q;
  end

  // R8: occupancy is bounded by the buffer size
  assert_used_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= (BW+1)'(BUF_BYTES));
  // R2: with no complete frame held, no bytes are held either
  assert_no_bytes_without_frames_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frames_q == '0) |-> (used_q == '0));
  // R2: a lone commit adds exactly one frame
  assert_commit_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !frame_done && !flush) |=> (frames_q == $past(frames_q) + (AW+1)'(1)));
  // R3: a dropped frame leaves the occupancy untouched
  assert_drop_keeps_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !do_pop && !flush) |=> (used_q == $past(used_q)));
  // R3: an overrun pulse is always accompanied by the sticky flag
  assert_ovr_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |-> stat_overrun);
  // R9: flush empties the buffer in one cycle
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (used_q == '0 && frames_q == '0 && rd_word == '0));
endmodule

// File: tb/sim_rx_word_stream_buf.sv
`timescale 1ns/1ps
module sim_rx_word_stream_buf;
  localparam int BUF = 256;
  localparam int WORDS = BUF / 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, pop = 1'b0, flush = 1'b0, clr_overrun = 1'b0;
  logic [31:0] in_word = '0;
  logic [31:0] out_word;
  logic        stat_not_empty, stat_empty, stat_full, stat_overrun, stat_busy, stat_idle;
  logic        ev_rx, ev_overrun;
  logic [7:0]  rd_ptr, wr_ptr;
  logic [6:0]  free_words, size_words, frames_stored;
  logic [15:0] frames_total;

  rx_word_stream_buf #(.BUF_BYTES(BUF), .TOTAL_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .in_word(in_word),
    .pop(pop), .out_word(out_word), .flush(flush), .clr_overrun(clr_overrun),
    .stat_not_empty(stat_not_empty), .stat_empty(stat_empty), .stat_full(stat_full),
    .stat_overrun(stat_overrun), .stat_busy(stat_busy), .stat_idle(stat_idle),
    .ev_rx(ev_rx), .ev_overrun(ev_overrun), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .free_words(free_words), .size_words(size_words), .frames_stored(frames_stored),
    .frames_total(frames_total)
  );

  int n_chk = 0, n_fail = 0;
  int rx_ev = 0, ov_ev = 0;
  int popped = 0;
  int accepted = 0;
  logic [7:0] tq[$];
  logic [4:0] wq[$];

  always @(posedge clk) begin
    if (ev_rx) rx_ev++;
    if (ev_overrun) ov_ev++;
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [4:0] wcnt, input logic [7:0] tag,
                                          input int k);
    if (k == 0) return (32'(wcnt) << 11) | 32'(tag);
    return {tag, 8'h5A, 16'(k)};
  endfunction

  task automatic push_frame(input logic [4:0] wcnt, input logic [7:0] tag);
    for (int k = 0; k <= int'(wcnt); k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (k == 0);
      in_word  = mk_word(wcnt, tag, k);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_frame(input logic [7:0] tag, input logic [4:0] wcnt);
    logic [6:0] f0;
    f0 = frames_stored;
    for (int k = 0; k <= int'(wcnt); k++) begin
      @(negedge clk);
      check("R1", "stream word", out_word, mk_word(wcnt, tag, k));
      if (k == int'(wcnt)) check("R5", "count held until last word", 32'(frames_stored), 32'(f0));
      pop = 1'b1;
    end
    @(negedge clk);
    pop = 1'b0;
    popped += int'(wcnt) + 1;
    check("R5", "count after last word", 32'(frames_stored), 32'(f0 - 7'd1));
  endtask

  task automatic check_occ(input string tagname, input int used_w);
    check("R7", {tagname, " free"}, 32'(free_words), 32'(WORDS - used_w));
    check("R8", {tagname, " full"}, 32'(stat_full), 32'(used_w == WORDS));
    check("R6", {tagname, " rd_ptr"}, 32'(rd_ptr), 32'((popped * 4) % BUF));
    check("R6", {tagname, " wr_ptr"}, 32'(wr_ptr), 32'(((popped + used_w) * 4) % BUF));
  endtask

  typedef struct packed {
    logic [4:0] wcnt;
    logic [1:0] drain;
    logic       acc;
    logic [6:0] used_w;
  } row_t;

  localparam row_t TBL [0:7] = '{
    '{5'd3,  2'd0, 1'b1, 7'd4},
    '{5'd31, 2'd0, 1'b1, 7'd36},
    '{5'd31, 2'd0, 1'b0, 7'd36},
    '{5'd27, 2'd0, 1'b1, 7'd64},
    '{5'd0,  2'd1, 1'b0, 7'd60},
    '{5'd0,  2'd0, 1'b1, 7'd61},
    '{5'd2,  2'd2, 1'b1, 7'd4},
    '{5'd7,  2'd2, 1'b1, 7'd8}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int rx0, ov0;
    logic [7:0] rp0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R8", "reset empty", 32'(stat_empty), 32'd1);
    check("R8", "reset not_empty", 32'(stat_not_empty), 32'd0);
    check("R7", "size words", 32'(size_words), 32'(WORDS));
    check("R5", "reset idle", 32'(stat_idle), 32'd1);
    check("R4", "reset out_word", out_word, 32'd0);
    check("R2", "reset total", 32'(frames_total), 32'd0);
    check("R10", "reset overrun", 32'(stat_overrun), 32'd0);
    check_occ("reset", 0);

    // R4: pop on an empty buffer
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    check("R4", "empty pop data", out_word, 32'd0);
    check_occ("R4 empty pop", 0);

    // R11: stray words without a header are ignored
    rx0 = rx_ev;
    @(negedge clk); in_valid = 1'b1; in_first = 1'b0; in_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", "stray frames", 32'(frames_stored), 32'd0);
    check("R11", "stray events", 32'(rx_ev - rx0), 32'd0);
    check_occ("R11 stray", 0);

    // R11: a new header mid-frame abandons the partial frame
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (k == 0); in_word = mk_word(5'd5, 8'hE1, k);
    end
    push_frame(5'd1, 8'hF1);
    accepted++;
    check("R11", "restart frames", 32'(frames_stored), 32'd1);
    check("R11", "restart events", 32'(rx_ev - rx0), 32'd1);
    check_occ("R11 restart", 2);
    read_frame(8'hF1, 5'd1);
    check_occ("R11 drained", 0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      logic [7:0] tag;
      tag = 8'(8'h10 + i);
      rx0 = rx_ev; ov0 = ov_ev;
      push_frame(TBL[i].wcnt, tag);
      if (TBL[i].acc) begin
        tq.push_back(tag); wq.push_back(TBL[i].wcnt); accepted++;
      end
      check("R2", "rx event", 32'(rx_ev - rx0), 32'(TBL[i].acc));
      check("R3", "overrun event", 32'(ov_ev - ov0), 32'(!TBL[i].acc));
      check("R3", "overrun flag", 32'(stat_overrun), 32'(!TBL[i].acc));
      check("R2", "total", 32'(frames_total), 32'(accepted));
      if (!TBL[i].acc) begin
        @(negedge clk); clr_overrun = 1'b1;
        @(negedge clk); clr_overrun = 1'b0;
        check("R10", "overrun cleared", 32'(stat_overrun), 32'd0);
      end
      for (int d = 0; d < int'(TBL[i].drain); d++) begin
        logic [7:0] t; logic [4:0] w;
        t = tq.pop_front(); w = wq.pop_front();
        read_frame(t, w);
      end
      check("R2", "frames stored", 32'(frames_stored), 32'(tq.size()));
      check("R8", "empty flag", 32'(stat_empty), 32'(tq.size() == 0));
      check("R2", "not empty", 32'(stat_not_empty), 32'(tq.size() != 0));
      check("R2", "busy", 32'(stat_busy), 32'(tq.size() != 0));
      check("R2", "idle", 32'(stat_idle), 32'(tq.size() == 0));
      check_occ("table", int'(TBL[i].used_w));
    end

    // R5: drain the rest, status returns to idle
    while (tq.size() != 0) begin
      logic [7:0] t; logic [4:0] w;
      t = tq.pop_front(); w = wq.pop_front();
      read_frame(t, w);
    end
    check("R5", "drained not_empty", 32'(stat_not_empty), 32'd0);
    check("R5", "drained busy", 32'(stat_busy), 32'd0);
    check("R5", "drained idle", 32'(stat_idle), 32'd1);
    check_occ("R5 drained", 0);

    // R9: flush after a partial read
    push_frame(5'd3, 8'hA1);
    push_frame(5'd1, 8'hB1);
    accepted += 2;
    @(negedge clk); pop = 1'b1;
    @(negedge clk);
    @(negedge clk); pop = 1'b0;
    popped += 2;
    check("R5", "mid-frame count", 32'(frames_stored), 32'd2);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    popped = 0;
    check("R9", "flush frames", 32'(frames_stored), 32'd0);
    check("R9", "flush idle", 32'(stat_idle), 32'd1);
    check("R9", "flush out_word", out_word, 32'd0);
    check("R9", "flush total kept", 32'(frames_total), 32'(accepted));
    check_occ("R9 flush", 0);
    push_frame(5'd2, 8'hC1);
    accepted++;
    read_frame(8'hC1, 5'd2);
    check_occ("R9 after flush", 0);

    // R10: overrun and clear in the same cycle, set wins
    push_frame(5'd31, 8'hD1);
    push_frame(5'd31, 8'hD2);
    accepted += 2;
    check("R8", "full", 32'(stat_full), 32'd1);
    @(negedge clk);
    in_valid = 1'b1; in_first = 1'b1; in_word = mk_word(5'd0, 8'hD3, 0); clr_overrun = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; clr_overrun = 1'b0;
    check("R10", "set wins over clear", 32'(stat_overrun), 32'd1);
    check("R3", "drop keeps count", 32'(frames_stored), 32'd2);
    check_occ("R3 full drop", WORDS);
    @(negedge clk); clr_overrun = 1'b1;
    @(negedge clk); clr_overrun = 1'b0;
    check("R10", "clear", 32'(stat_overrun), 32'd0);
    read_frame(8'hD1, 5'd31);
    read_frame(8'hD2, 5'd31);
    check("R5", "final idle", 32'(stat_idle), 32'd1);

    // R4: empty pop at a non-zero pointer
    @(negedge clk);
    rp0 = rd_ptr;
    pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    check("R4", "late empty pop data", out_word, 32'd0);
    check("R4", "late empty pop ptr", 32'(rd_ptr), 32'(rp0));
    check("R4", "late empty pop free", 32'(free_words), 32'(WORDS));

    summary();
    $finish;
  end
endmodule